// File: doc/BRIEF.md
# Sound RAM transfer register interface

This block is the register front of an audio unit. Its registers are 16 bits wide and sit in a 1 KiB window. A host on a 32-bit bus reaches them through a small splitter. The splitter turns each 32-bit access into two 16-bit register accesses on consecutive cycles. The lower half always goes first.

The host programs a start location in the transfer-address register. The value is held in units of 8 bytes. The block expands it into a byte pointer into a local sound RAM. Each halfword written to the data port is stored at that pointer, and the pointer then moves on by two bytes. It wraps at the end of the RAM. A two-bit transfer-mode field in the control register drives a request line to the system DMA engine. The DMA data path is only a stub: reads return all ones and writes are discarded. A synchronous read port lets the sample engine fetch RAM words.

Top module: `sound_xfer_regs`

## Requirements
- R1: A 16-bit write to the transfer-address register (halfword index 0x0D3, byte offset 0x1A6) stores the value. A later read returns it unchanged.
- R2: The same write loads the byte pointer with value*8, truncated to the RAM size of 2^RAM_AW bytes. The next data-port write lands at RAM word (value*4) mod (2^RAM_AW/2).
- R3: A 16-bit write to the data port (index 0x0D4, offset 0x1A8) stores the halfword at the pointer. The pointer then advances by 2 bytes and wraps from the last word to word 0.
- R4: Control register bits 5:4 select the transfer mode: 0 stopped, 1 manual write, 2 DMA write, 3 DMA read. From the cycle after a control write, `dma_req` is 1 exactly when the mode is 2 or 3.
- R5: A write to the control register (index 0x0D5, offset 0x1AA) stores all 16 bits. A read returns them.
- R6: The status register (index 0x0D7, offset 0x1AE) reads 0 and ignores writes.
- R7: Reads of the data port or of any unmapped index return 0xFFFF. Writes to unmapped indices change no register, no RAM word and no output.
- R8: A 32-bit write (`bus_wide`=1) performs a 16-bit write of bits 15:0 at the given index, followed one cycle later by a write of bits 31:16 at index+1. `bus_ready` is 0 during the second cycle.
- R9: `bus_rvalid` pulses one cycle after a 16-bit read, with bits 31:16 zero. For a 32-bit read it pulses two cycles after acceptance, with bits 15:0 from the given index and bits 31:16 from index+1.
- R10: Reset clears the address, control and status registers, the pointer and `dma_req`.
- R11: A DMA read or write strobe is acknowledged in the same cycle. A DMA read returns 0xFFFFFFFF.
- R12: The sample read port returns the RAM word at `snd_raddr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_valid | input | 1 | access request |
| bus_ready | output | 1 | request accepted when high |
| bus_write | input | 1 | 1 write, 0 read |
| bus_wide | input | 1 | 1 for a 32-bit access |
| bus_idx | input | 9 | halfword index (byte offset / 2) |
| bus_wdata | input | 32 | write data |
| bus_rvalid | output | 1 | read data valid |
| bus_rdata | output | 32 | read data |
| dma_req | output | 1 | DMA request |
| dma_rd | input | 1 | DMA read strobe |
| dma_wr | input | 1 | DMA write strobe |
| dma_ack | output | 1 | DMA strobe acknowledge |
| dma_rdata | output | 32 | DMA read data |
| snd_raddr | input | RAM_AW-1 | sample fetch word address |
| snd_rdata | output | 16 | sample fetch data |

## Verification
On every cycle, the assertions check several properties:
- the DMA request against the stored mode and against the last control write;
- the one-word pointer step after each data write;
- the stall during the second half of a wide access;
- the read-valid timing and the zero upper half of narrow reads;
- the DMA acknowledge.

Only the bench's scenarios can show where data actually lands in RAM. This covers the address scaling, the wrap at the top of RAM, and a wide write whose halves hit the address register and then the data port. The scenarios also show that dropped writes leave the registers and the RAM unchanged.

// File: rtl/sound_xfer_regs.sv
module sound_xfer_regs #(
  parameter int RAM_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic              bus_wide,
  input  logic [8:0]        bus_idx,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              dma_req,
  input  logic              dma_rd,
  input  logic              dma_wr,
  output logic              dma_ack,
  output logic [31:0]       dma_rdata,
  input  logic [RAM_AW-2:0] snd_raddr,
  output logic [15:0]       snd_rdata
);
  localparam int WW    = RAM_AW - 1;
  localparam int WORDS = 1 << WW;
  localparam logic [8:0] IDX_ADDR = 9'h0D3;
  localparam logic [8:0] IDX_DATA = 9'h0D4;
  localparam logic [8:0] IDX_CTL  = 9'h0D5;
  localparam logic [8:0] IDX_STAT = 9'h0D7;

  logic          phase2;
  logic [8:0]    hi_idx;
  logic [15:0]   hi_wd;
  logic          hi_we;
  logic [15:0]   lo_rd;

  logic [15:0]   addr_q, ctl_q, stat_q;
  logic [WW-1:0] ptr_q;
  logic [15:0]   mem [WORDS];

  logic          accept, op_en, op_we;
  logic [8:0]    op_idx;
  logic [15:0]   op_wd, rd16;
  logic [17:0]   load_full;

  assign bus_ready = ~phase2;
  assign accept    = bus_valid & bus_ready;
  assign op_en     = accept | phase2;
  assign op_idx    = phase2 ? hi_idx : bus_idx;
  assign op_we     = phase2 ? hi_we  : bus_write;
  assign op_wd     = phase2 ? hi_wd  : bus_wdata[15:0];
  assign load_full = {op_wd, 2'b00};

  always_comb begin
    case (op_idx)
      IDX_ADDR: rd16 = addr_q;
      IDX_CTL:  rd16 = ctl_q;
      IDX_STAT: rd16 = stat_q;
      default:  rd16 = 16'hFFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase2     <= 1'b0;
      hi_idx     <= '0;
      hi_wd      <= '0;
      hi_we      <= 1'b0;
      lo_rd      <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= 1'b0;
      if (phase2) begin
        phase2 <= 1'b0;
        if (!hi_we) begin
          bus_rvalid <= 1'b1;
          bus_rdata  <= {rd16, lo_rd};
        end
      end else if (accept) begin
        if (bus_wide) begin
          phase2 <= 1'b1;
          hi_idx <= bus_idx + 9'd1;
          hi_wd  <= bus_wdata[31:16];
          hi_we  <= bus_write;
          lo_rd  <= rd16;
        end else if (!bus_write) begin
          bus_rvalid <= 1'b1;
          bus_rdata  <= {16'h0000, rd16};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      ctl_q   <= '0;
      stat_q  <= '0;
      ptr_q   <= '0;
      dma_req <= 1'b0;
    end else if (op_en && op_we) begin
      case (op_idx)
        IDX_ADDR: begin
          addr_q <= op_wd;
          ptr_q  <= load_full[WW-1:0];
        end
        IDX_DATA: ptr_q <= ptr_q + 1'b1;
        IDX_CTL: begin
          ctl_q   <= op_wd;
          dma_req <= op_wd[5];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op_en && op_we && op_idx == IDX_DATA) mem[ptr_q] <= op_wd;
    snd_rdata <= mem[snd_raddr];
  end

  assign dma_ack   = dma_rd | dma_wr;
  assign dma_rdata = dma_rd ? 32'hFFFF_FFFF : 32'h0000_0000;
endmodule

// File: rtl/sound_xfer_regs_chk.sv
module sound_xfer_regs_chk #(
  parameter int RAM_AW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic              bus_wide,
  input logic [8:0]        bus_idx,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic [31:0]       bus_rdata,
  input logic              dma_req,
  input logic              dma_rd,
  input logic              dma_wr,
  input logic              dma_ack,
  input logic [31:0]       dma_rdata,
  input logic [15:0]       ctl_q,
  input logic [RAM_AW-2:0] ptr_q,
  input logic              op_en,
  input logic              op_we,
  input logic [8:0]        op_idx
);
  logic acc;
  assign acc = bus_valid & bus_ready;

  a_r4_req_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> dma_req == ctl_q[5]);

  a_r4_req_after_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_write && !bus_wide && bus_idx == 9'h0D5) |=> dma_req == $past(bus_wdata[5]));

  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_we && op_idx == 9'h0D4) |=> ptr_q == $past(ptr_q) + 1'b1);

  a_r8_stall_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_wide) |=> !bus_ready);

  a_r9_narrow_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !bus_write && !bus_wide) |=> bus_rvalid && bus_rdata[31:16] == 16'h0000);

  a_r9_wide_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !bus_write && bus_wide) |=> !bus_rvalid ##1 bus_rvalid);

  a_r11_dma_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd || dma_wr) |-> dma_ack);

  a_r11_dma_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd |-> dma_rdata == 32'hFFFF_FFFF);
endmodule

bind sound_xfer_regs sound_xfer_regs_chk #(.RAM_AW(RAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_write(bus_write), .bus_wide(bus_wide), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .dma_req(dma_req), .dma_rd(dma_rd),
  .dma_wr(dma_wr), .dma_ack(dma_ack), .dma_rdata(dma_rdata), .ctl_q(ctl_q),
  .ptr_q(ptr_q), .op_en(op_en), .op_we(op_we), .op_idx(op_idx)
);

// File: tb/test_sound_xfer_regs.sv
`timescale 1ns/1ps
module test_sound_xfer_regs;
  localparam int AW = 12;
  localparam int WORDS = 1 << (AW - 1);

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, bus_wide = 0;
  logic [8:0] bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, bus_rvalid, dma_req, dma_ack;
  logic [31:0] bus_rdata, dma_rdata;
  logic dma_rd = 0, dma_wr = 0;
  logic [AW-2:0] snd_raddr = '0;
  logic [15:0] snd_rdata;

  int tests = 0, fails = 0;
  logic [15:0] m_addr, m_ctl;
  int m_ptr;
  logic [15:0] m_mem [WORDS];
  bit m_set [WORDS];

  always #4 clk = ~clk;

  sound_xfer_regs #(.RAM_AW(AW)) i_sound_xfer_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_wide(bus_wide), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .dma_req(dma_req), .dma_rd(dma_rd),
    .dma_wr(dma_wr), .dma_ack(dma_ack), .dma_rdata(dma_rdata),
    .snd_raddr(snd_raddr), .snd_rdata(snd_rdata));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [8:0] idx);
    case (idx)
      9'h0D3: return m_addr;
      9'h0D5: return m_ctl;
      9'h0D7: return 16'h0000;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic model_wr(input logic [8:0] idx, input logic [15:0] d);
    case (idx)
      9'h0D3: begin m_addr = d; m_ptr = (int'(d) * 4) % WORDS; end
      9'h0D4: begin m_mem[m_ptr] = d; m_set[m_ptr] = 1; m_ptr = (m_ptr + 1) % WORDS; end
      9'h0D5: m_ctl = d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [8:0] idx, input logic [31:0] d, input bit wide);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_wide = wide; bus_idx = idx; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0;
    model_wr(idx, d[15:0]);
    if (wide) begin
      check(bus_ready == 0, "R8 ready low in second half", {31'd0, bus_ready}, 0);
      @(negedge clk);
      model_wr(idx + 9'd1, d[31:16]);
    end
  endtask

  task automatic rd(input logic [8:0] idx, input bit wide, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_wide = wide; bus_idx = idx;
    @(negedge clk);
    bus_valid = 0;
    if (wide) begin
      check(bus_rvalid == 0, {req, " R9 early valid"}, {31'd0, bus_rvalid}, 0);
      @(negedge clk);
      e = {exp_rd(idx + 9'd1), exp_rd(idx)};
    end else e = {16'h0000, exp_rd(idx)};
    check(bus_rvalid == 1, {req, " R9 rvalid"}, {31'd0, bus_rvalid}, 1);
    check(bus_rdata == e, req, bus_rdata, e);
  endtask

  task automatic peek(input int w, input string req);
    @(negedge clk);
    snd_raddr = w[AW-2:0];
    @(negedge clk);
    check(snd_rdata == m_mem[w], req, {16'h0, snd_rdata}, {16'h0, m_mem[w]});
  endtask

  task automatic chk_req(input string req);
    check(dma_req == m_ctl[5], req, {31'd0, dma_req}, {31'd0, m_ctl[5]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_addr = 0; m_ctl = 0; m_ptr = 0;
    for (int i = 0; i < WORDS; i++) begin m_mem[i] = 0; m_set[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    rd(9'h0D3, 0, "R10 addr reset");
    rd(9'h0D5, 0, "R10 ctl reset");
    check(dma_req == 0, "R10 dma_req reset", {31'd0, dma_req}, 0);
    // R1 R2 R3 basic transfer
    wr(9'h0D3, 32'h0000_0010, 0);
    rd(9'h0D3, 0, "R1 addr readback");
    wr(9'h0D4, 32'h0000_ABCD, 0);
    wr(9'h0D4, 32'h0000_1234, 0);
    peek(64, "R2 first word at value*4");
    peek(65, "R3 pointer advance");
    // R3 wrap
    wr(9'h0D3, 32'h0000_01FF, 0);
    for (int i = 0; i < 5; i++) wr(9'h0D4, 32'h0000_7700 + i, 0);
    peek(WORDS - 1, "R3 last word");
    peek(0, "R3 wrap to word 0");
    wr(9'h0D3, 32'h0000_FFFF, 0);
    wr(9'h0D4, 32'h0000_5A5A, 0);
    peek(m_ptr - 1, "R2 truncated pointer");
    // R4 R5 modes
    for (int m = 0; m < 4; m++) begin
      wr(9'h0D5, 32'h0000_C000 | (m << 4), 0);
      chk_req("R4 dma_req per mode");
      rd(9'h0D5, 0, "R5 ctl readback");
    end
    // R6 status
    wr(9'h0D7, 32'h0000_FFFF, 0);
    rd(9'h0D7, 0, "R6 status reads zero");
    // R7 data port and unmapped
    rd(9'h0D4, 0, "R7 data port read");
    rd(9'h0D6, 0, "R7 unmapped read");
    wr(9'h0D6, 32'h0000_0030, 0);
    wr(9'h012, 32'h0000_ABCD, 0);
    chk_req("R7 unmapped write no dma change");
    rd(9'h0D3, 1, "R7 regs unchanged after unmapped write");
    wr(9'h0D4, 32'h0000_0BAD, 0);
    peek(m_ptr - 1, "R7 pointer unchanged after unmapped write");
    // R8 wide write: addr then data
    wr(9'h0D3, 32'hCAFE_0020, 1);
    peek(128, "R8 high half to data port at new pointer");
    rd(9'h0D3, 0, "R8 low half to addr");
    wr(9'h0D4, 32'h0020_BEEF, 1);
    chk_req("R8 high half into control");
    rd(9'h0D5, 0, "R8 control from high half");
    // R9 wide reads
    rd(9'h0D3, 1, "R9 wide read addr+data");
    rd(9'h0D5, 1, "R9 wide read ctl+unmapped");
    // R11 DMA stub
    @(negedge clk); dma_rd = 1;
    #1 check(dma_ack == 1 && dma_rdata == 32'hFFFF_FFFF, "R11 dma read", dma_rdata, 32'hFFFF_FFFF);
    @(negedge clk); dma_rd = 0; dma_wr = 1;
    #1 check(dma_ack == 1, "R11 dma write ack", {31'd0, dma_ack}, 1);
    @(negedge clk); dma_wr = 0;
    // random mix, R12 sample port
    for (int n = 0; n < 400; n++) begin
      logic [8:0] idx;
      int k;
      k = $urandom_range(0, 6);
      case (k)
        0: idx = 9'h0D3;
        1, 2: idx = 9'h0D4;
        3: idx = 9'h0D5;
        4: idx = 9'h0D7;
        5: idx = 9'h0D2;
        default: idx = 9'($urandom);
      endcase
      if ($urandom_range(0, 1)) wr(idx, $urandom, $urandom_range(0, 1));
      else rd(idx, $urandom_range(0, 1), "R9 random read");
      chk_req("R4 random dma_req");
      if (m_set[(m_ptr + WORDS - 1) % WORDS]) peek((m_ptr + WORDS - 1) % WORDS, "R12 sample fetch");
    end
    // R10 reset again
    wr(9'h0D5, 32'h0000_0030, 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_addr = 0; m_ctl = 0; m_ptr = 0;
    check(dma_req == 0, "R10 dma_req cleared", {31'd0, dma_req}, 0);
    rd(9'h0D5, 1, "R10 regs cleared");
    wr(9'h0D4, 32'h0000_3C3C, 0);
    peek(0, "R10 pointer cleared");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule